// File: doc/BRIEF.md
# Multichannel Zero-Input Detector

This block watches the sample words of several DAC channels, one beat per audio frame, and counts how many frames in a row each channel has carried an all-zero word. When a channel's run reaches a long threshold, its zero flag sets. A single non-zero word clears that flag on the same frame. Two output pins each report the AND of the zero flags of the channels selected by that pin's own mask.

A global enable, per-channel power bits, a soft-run control and a polarity bit change what the pins report. While the soft-run control is low, the pins are forced to their asserted level. After it returns high, they stay asserted for a short hold-off before they follow detection again.

The sample input is a valid-only stream. Every beat presented with `frm_valid` high is consumed in that cycle, and there is no back-pressure. Masks and control bits are plain level inputs.

Top module: `zero_detect`

## Requirements
- R1: Each channel has a run counter. It advances by one only on a beat whose word for that channel is all zero, and it saturates at RUN_LEN. The channel's zero flag is set exactly while the counter equals RUN_LEN.
- R2: A beat carrying a non-zero word for a channel clears that channel's counter and flag at that clock edge. A pin that depends on the channel falls in the next cycle.
- R3: Bit i of `mask_a` (or `mask_b`) selects channel i for `flag_a` (or `flag_b`). The pin is the AND of the selected zero flags. A pin whose mask is all zero stays deasserted.
- R4: While `run_n` is 0, both pins are at the asserted level and all run counters are held at 0.
- R5: After `run_n` returns to 1, the pins stay asserted until HOLDOFF beats have been received. From then on they follow detection.
- R6: While `det_en` is 0, both pins are deasserted.
- R7: When every `pwr_on` bit is 0, both pins are deasserted. A channel whose bit is 0 is still counted, so its words must be zero for the others to report.
- R8: `flag_inv` = 1 inverts both pins. The inversion is applied after every other rule.
- R9: The rules take effect in this priority order: disable, then all powered down, then soft run low, then hold-off, then detection.
- R10: Channel i's word sits in `frm_data[i*SAMPLE_W +: SAMPLE_W]`. After the hard reset `rst_n`, all counters are 0, no hold-off is pending, and the pins are deasserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hard reset, active low |
| frm_valid | input | 1 | One beat per frame; always accepted |
| frm_data | input | NUM_CH*SAMPLE_W | Sample words of all channels for this frame |
| mask_a | input | NUM_CH | Channel select for flag_a |
| mask_b | input | NUM_CH | Channel select for flag_b |
| pwr_on | input | NUM_CH | Per-channel power bits |
| det_en | input | 1 | Detection enable |
| run_n | input | 1 | Soft run control; 0 holds the detector in reset |
| flag_inv | input | 1 | Output polarity invert |
| flag_a | output | 1 | Zero flag pin A |
| flag_b | output | 1 | Zero flag pin B |

## Verification
The bench builds the block with four channels of 8-bit words, RUN_LEN of 16 and HOLDOFF of 4. The short run length lets saturation, re-arming after a single non-zero word, and a full re-set after a soft reset all fit in a few dozen frames. Four channels split across the two masks allow one pin to clear while the other holds, and the 8-bit words make each channel's field easy to target.

// File: rtl/zd_pkg.sv
package zd_pkg;
  typedef enum logic [1:0] {
    ZD_LOW    = 2'd0,
    ZD_HIGH   = 2'd1,
    ZD_DETECT = 2'd2
  } zd_mode_e;
endpackage

// File: rtl/zd_run_counter.sv
module zd_run_counter #(
  parameter int SAMPLE_W = 24,
  parameter int RUN_LEN  = 8192
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                step,
  input  logic [SAMPLE_W-1:0] sample,
  output logic                zero_flag
);
  localparam int CW = $clog2(RUN_LEN + 1);
  localparam logic [CW-1:0] LIMIT = CW'(RUN_LEN);

  logic [CW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (clr) begin
      run_q <= '0;
    end else if (step) begin
      if (sample != '0)       run_q <= '0;
      else if (run_q != LIMIT) run_q <= run_q + 1'b1;
    end
  end

  assign zero_flag = (run_q == LIMIT);
endmodule

// File: rtl/zd_holdoff.sv
module zd_holdoff #(
  parameter int HOLDOFF = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_n,
  input  logic step,
  output logic holding
);
  localparam int HW = $clog2(HOLDOFF + 1);
  localparam logic [HW-1:0] DONE = HW'(HOLDOFF);

  logic [HW-1:0] hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= DONE;
    end else if (!run_n) begin
      hold_q <= '0;
    end else if (step && hold_q != DONE) begin
      hold_q <= hold_q + 1'b1;
    end
  end

  assign holding = (hold_q != DONE);
endmodule

// File: rtl/zd_flag_out.sv
module zd_flag_out
  import zd_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  zd_mode_e          mode,
  input  logic [NUM_CH-1:0] zero_vec,
  input  logic [NUM_CH-1:0] mask,
  input  logic              inv,
  output logic              flag
);
  logic all_zero;

  assign all_zero = (|mask) && (&(zero_vec | ~mask));

  always_comb begin
    unique case (mode)
      ZD_HIGH:   flag = 1'b1 ^ inv;
      ZD_DETECT: flag = all_zero ^ inv;
      default:   flag = inv;
    endcase
  end
endmodule

// File: rtl/zero_detect.sv
module zero_detect
  import zd_pkg::*;
#(
  parameter int NUM_CH   = 8,
  parameter int SAMPLE_W = 24,
  parameter int RUN_LEN  = 8192,
  parameter int HOLDOFF  = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       frm_valid,
  input  logic [NUM_CH*SAMPLE_W-1:0] frm_data,
  input  logic [NUM_CH-1:0]          mask_a,
  input  logic [NUM_CH-1:0]          mask_b,
  input  logic [NUM_CH-1:0]          pwr_on,
  input  logic                       det_en,
  input  logic                       run_n,
  input  logic                       flag_inv,
  output logic                       flag_a,
  output logic                       flag_b
);
  localparam int NUM_OUT = 2;

  logic [NUM_CH-1:0] zero_vec;
  logic              holding;
  zd_mode_e          mode;
  logic [NUM_CH-1:0] masks [NUM_OUT];
  logic [NUM_OUT-1:0] flags;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    zd_run_counter #(
      .SAMPLE_W (SAMPLE_W),
      .RUN_LEN  (RUN_LEN)
    ) u_run (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (!run_n),
      .step      (frm_valid),
      .sample    (frm_data[c*SAMPLE_W +: SAMPLE_W]),
      .zero_flag (zero_vec[c])
    );
  end

  zd_holdoff #(.HOLDOFF(HOLDOFF)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .run_n   (run_n),
    .step    (frm_valid),
    .holding (holding)
  );

  always_comb begin
    if (!det_en)                mode = ZD_LOW;
    else if (pwr_on == '0)      mode = ZD_LOW;
    else if (!run_n || holding) mode = ZD_HIGH;
    else                        mode = ZD_DETECT;
  end

  assign masks[0] = mask_a;
  assign masks[1] = mask_b;

  for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
    zd_flag_out #(.NUM_CH(NUM_CH)) u_out (
      .mode     (mode),
      .zero_vec (zero_vec),
      .mask     (masks[o]),
      .inv      (flag_inv),
      .flag     (flags[o])
    );
  end

  assign flag_a = flags[0];
  assign flag_b = flags[1];
endmodule

// File: rtl/zero_detect_chk.sv
module zero_detect_chk #(
  parameter int NUM_CH   = 8,
  parameter int SAMPLE_W = 24
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       frm_valid,
  input logic [NUM_CH*SAMPLE_W-1:0] frm_data,
  input logic [NUM_CH-1:0]          pwr_on,
  input logic                       det_en,
  input logic                       run_n,
  input logic                       flag_inv,
  input logic                       flag_a,
  input logic                       flag_b,
  input logic [NUM_CH-1:0]          zero_vec
);
  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    a_r2_clear_on_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      frm_valid && (frm_data[c*SAMPLE_W +: SAMPLE_W] != '0) |=> !zero_vec[c]);

    a_r1_set_needs_beat: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok && $rose(zero_vec[c]) |-> $past(frm_valid) && $past(run_n));
  end

  a_r4_soft_reset_high: assert property (@(posedge clk) disable iff (!rst_n)
    !run_n && det_en && (pwr_on != '0) |-> (flag_a != flag_inv) && (flag_b != flag_inv));

  a_r5_holdoff_high: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && run_n && !$past(run_n) && det_en && (pwr_on != '0)
      |-> (flag_a != flag_inv) && (flag_b != flag_inv));

  a_r6_disable_low: assert property (@(posedge clk) disable iff (!rst_n)
    !det_en |-> (flag_a == flag_inv) && (flag_b == flag_inv));

  a_r7_all_off_low: assert property (@(posedge clk) disable iff (!rst_n)
    det_en && (pwr_on == '0) |-> (flag_a == flag_inv) && (flag_b == flag_inv));
endmodule

bind zero_detect zero_detect_chk #(
  .NUM_CH   (NUM_CH),
  .SAMPLE_W (SAMPLE_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .frm_valid (frm_valid),
  .frm_data  (frm_data),
  .pwr_on    (pwr_on),
  .det_en    (det_en),
  .run_n     (run_n),
  .flag_inv  (flag_inv),
  .flag_a    (flag_a),
  .flag_b    (flag_b),
  .zero_vec  (zero_vec)
);

// File: tb/zero_detect_bench.sv
module zero_detect_bench;
  localparam int NUM_CH   = 4;
  localparam int SAMPLE_W = 8;
  localparam int RUN_LEN  = 16;
  localparam int HOLDOFF  = 4;
  localparam int DW       = NUM_CH * SAMPLE_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frm_valid = 1'b0;
  logic [DW-1:0] frm_data = '0;
  logic [NUM_CH-1:0] mask_a = 4'b0011;
  logic [NUM_CH-1:0] mask_b = 4'b1100;
  logic [NUM_CH-1:0] pwr_on = 4'b1111;
  logic det_en = 1'b1;
  logic run_n = 1'b1;
  logic flag_inv = 1'b0;
  logic flag_a, flag_b;

  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  zero_detect #(
    .NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W), .RUN_LEN(RUN_LEN), .HOLDOFF(HOLDOFF)
  ) u_zero_detect (
    .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_data(frm_data),
    .mask_a(mask_a), .mask_b(mask_b), .pwr_on(pwr_on), .det_en(det_en),
    .run_n(run_n), .flag_inv(flag_inv), .flag_a(flag_a), .flag_b(flag_b)
  );

  // row: {frame data, repeat count, expected flag_a, expected flag_b}
  localparam int NV = 8;
  localparam logic [41:0] VEC [NV] = '{
    {32'h0000_0000, 8'd15, 1'b0, 1'b0},  // R1 one short of the run
    {32'h0000_0000, 8'd1,  1'b1, 1'b1},  // R1 run complete
    {32'h0000_0001, 8'd1,  1'b0, 1'b1},  // R2 ch0 non-zero clears A only
    {32'h0000_0000, 8'd15, 1'b0, 1'b1},  // R1 ch0 re-counting
    {32'h0000_0000, 8'd1,  1'b1, 1'b1},  // R1 ch0 re-set
    {32'h0100_0000, 8'd1,  1'b1, 1'b0},  // R2 ch3 non-zero clears B only
    {32'h0080_0000, 8'd16, 1'b1, 1'b0},  // R3 ch2 keeps B low
    {32'h0000_0000, 8'd16, 1'b1, 1'b1}   // R3 both masks all-zero
  };

  task automatic check(input string req, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  task automatic send(input logic [DW-1:0] d, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      frm_valid = 1'b1;
      frm_data  = d;
      @(negedge clk);
      frm_valid = 1'b0;
      frm_data  = '0;
    end
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();
    check("R10 reset flag_a", flag_a, 1'b0);
    check("R10 reset flag_b", flag_b, 1'b0);

    for (int v = 0; v < NV; v++) begin
      send(VEC[v][41:10], int'(VEC[v][9:2]));
      check($sformatf("R1/R2/R3 row %0d flag_a", v), flag_a, VEC[v][1]);
      check($sformatf("R1/R2/R3 row %0d flag_b", v), flag_b, VEC[v][0]);
    end

    // R3 empty mask
    mask_b = '0; settle();
    check("R3 empty mask flag_b", flag_b, 1'b0);
    mask_b = 4'b1100; settle();

    // R8 inversion
    flag_inv = 1'b1; settle();
    check("R8 inverted flag_a", flag_a, 1'b0);
    check("R8 inverted flag_b", flag_b, 1'b0);
    flag_inv = 1'b0;

    // R6 disable, R8 applied last
    det_en = 1'b0; settle();
    check("R6 disabled flag_a", flag_a, 1'b0);
    check("R6 disabled flag_b", flag_b, 1'b0);
    flag_inv = 1'b1; settle();
    check("R8 disabled inverted flag_a", flag_a, 1'b1);
    flag_inv = 1'b0; det_en = 1'b1; settle();
    check("R6 re-enabled flag_a", flag_a, 1'b1);

    // R7 power bits
    pwr_on = '0; settle();
    check("R7 all off flag_a", flag_a, 1'b0);
    check("R7 all off flag_b", flag_b, 1'b0);
    pwr_on = 4'b1110; settle();
    check("R7 partial power flag_a", flag_a, 1'b1);
    send(32'h0000_0005, 1);
    check("R7 powered-off ch0 still counted", flag_a, 1'b0);
    send('0, RUN_LEN);
    check("R7 ch0 re-set", flag_a, 1'b1);
    pwr_on = 4'b1111;

    // R9 priority: disable beats soft reset; R4 soft reset forces high
    run_n = 1'b0; det_en = 1'b0; settle();
    check("R9 disable over soft reset", flag_a, 1'b0);
    det_en = 1'b1; settle();
    check("R4 soft reset flag_a", flag_a, 1'b1);
    check("R4 soft reset flag_b", flag_b, 1'b1);
    send(32'h0101_0101, 2);
    check("R4 soft reset ignores data", flag_b, 1'b1);
    run_n = 1'b1; settle();
    send(32'h0101_0101, HOLDOFF - 1);
    check("R5 hold-off flag_a", flag_a, 1'b1);
    check("R5 hold-off flag_b", flag_b, 1'b1);
    send(32'h0101_0101, 1);
    check("R5 after hold-off flag_a", flag_a, 1'b0);
    check("R5 after hold-off flag_b", flag_b, 1'b0);

    // R4 counters were cleared: a full run is needed again
    send('0, RUN_LEN - 1);
    check("R4 cleared counters flag_a", flag_a, 1'b0);
    send('0, 1);
    check("R1 run after release flag_a", flag_a, 1'b1);
    check("R1 run after release flag_b", flag_b, 1'b1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule